// File: doc/BRIEF.md
# I2C Line Spike Filter

This block removes short glitches from the clock and data lines of a two-wire serial bus before they reach the protocol logic. It sits after the input synchronizers. Each line has its own filter, and the two filters behave the same way. A filtered output takes a new level only after the raw input has held that level for more clock cycles than a programmed rejection length. Any pulse of that length or shorter is absorbed.

The rejection length is a 4-bit value in the range 0 to 15. Software loads it through a write strobe, and the load is accepted only while the peripheral enable is low. A length of zero gives plain pass-through with one register stage. A length N rejects pulses of up to N cycles and delays every accepted edge by N+1 cycles. Both filtered outputs come out of reset high, which is the idle bus level.

Top module: `i2c_spike_filter`

## Requirements
- R1: During reset and right after it, both filtered outputs are 1 and the rejection length is 0, so a one-cycle low pulse then passes with one cycle of delay.
- R2: With length 0, each filtered output equals its raw input from the previous clock edge.
- R3: With length N > 0, a raw level that differs from the output and holds for at least N+1 consecutive clock edges appears at the output N+1 edges after the first edge that samples it.
- R4: With length N, a raw pulse that lasts N cycles or fewer never reaches the output. The output changes only after an edge at which the raw input differed from it.
- R5: The SCL and SDA filters are independent. A pulse on one line leaves the other filtered output unchanged.
- R6: When `cfg_we` is 1 and `periph_en` is 0 at a clock edge, `cfg_len` becomes the rejection length from the next edge on.
- R7: When `periph_en` is 1, `cfg_we` has no effect and the rejection length stays the same.
- R8: A sample at which the raw input matches the output again restarts the count. Consecutive short glitches separated by one clean cycle do not add up to a change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| periph_en | input | 1 | Peripheral enable; locks the rejection length while high |
| cfg_we | input | 1 | Write strobe for the rejection length |
| cfg_len | input | 4 | New rejection length, in clock cycles |
| scl_raw | input | 1 | Synchronized clock line before filtering |
| sda_raw | input | 1 | Synchronized data line before filtering |
| scl_flt | output | 1 | Filtered clock line |
| sda_flt | output | 1 | Filtered data line |

## Verification
A length write is in effect at the edge after the strobe. A raw level change first sampled at edge k reaches the output after edge k+N, where N is the rejection length; with N = 0 it arrives after edge k. The bench drives inputs at falling edges and samples once per cycle at the falling edge, before it drives. It records the index of the first cycle in which the output is low and the number of low cycles, and compares both with N+1 and with the pulse width, or with zero for a rejected pulse.

// File: rtl/i2c_spike_filter_pkg.sv
package i2c_spike_filter_pkg;
    localparam int unsigned FLT_LEN_W = 4;

    typedef logic [FLT_LEN_W-1:0] flt_len_t;

    typedef struct packed {
        logic     lvl;
        flt_len_t cnt;
    } flt_line_st_t;
endpackage

// File: rtl/flt_len_reg.sv
module flt_len_reg
    import i2c_spike_filter_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     periph_en,
    input  logic     cfg_we,
    input  flt_len_t cfg_len,
    output flt_len_t len_q
);
    flt_len_t len_d;

    always_comb begin
        len_d = len_q;
        if (cfg_we && !periph_en) begin
            len_d = cfg_len;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '0;
        end else begin
            len_q <= len_d;
        end
    end
endmodule

// File: rtl/flt_line.sv
module flt_line
    import i2c_spike_filter_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  flt_len_t len,
    input  logic     raw,
    output logic     flt
);
    flt_line_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (raw == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= len) begin
            st_d.lvl = raw;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{lvl: 1'b1, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign flt = st_q.lvl;
endmodule

// File: rtl/i2c_spike_filter.sv
module i2c_spike_filter
    import i2c_spike_filter_pkg::*;
#(
    parameter int unsigned NUM_LINES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       periph_en,
    input  logic       cfg_we,
    input  logic [3:0] cfg_len,
    input  logic       scl_raw,
    input  logic       sda_raw,
    output logic       scl_flt,
    output logic       sda_flt
);
    localparam int unsigned LINE_IDX_SCL = 0;
    localparam int unsigned LINE_IDX_SDA = 1;

    flt_len_t             cur_len;
    logic [NUM_LINES-1:0] raw_vec;
    logic [NUM_LINES-1:0] flt_vec;

    flt_len_reg u_len (
        .clk       (clk),
        .rst_n     (rst_n),
        .periph_en (periph_en),
        .cfg_we    (cfg_we),
        .cfg_len   (cfg_len),
        .len_q     (cur_len)
    );

    assign raw_vec[LINE_IDX_SCL] = scl_raw;
    assign raw_vec[LINE_IDX_SDA] = sda_raw;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        flt_line u_line (
            .clk   (clk),
            .rst_n (rst_n),
            .len   (cur_len),
            .raw   (raw_vec[g]),
            .flt   (flt_vec[g])
        );
    end

    assign scl_flt = flt_vec[LINE_IDX_SCL];
    assign sda_flt = flt_vec[LINE_IDX_SDA];
endmodule

// File: rtl/i2c_spike_filter_chk.sv
module i2c_spike_filter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       periph_en,
    input logic       cfg_we,
    input logic [3:0] cfg_len,
    input logic       scl_raw,
    input logic       sda_raw,
    input logic       scl_flt,
    input logic       sda_flt,
    input logic [3:0] cur_len
);
    assert_len_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !periph_en) |=> (cur_len == $past(cfg_len)));

    assert_len_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        periph_en |=> $stable(cur_len));

    assert_scl_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cur_len) == 4'd0) |-> (scl_flt == $past(scl_raw)));

    assert_sda_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cur_len) == 4'd0) |-> (sda_flt == $past(sda_raw)));

    assert_scl_toggle_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_flt != $past(scl_flt)) |-> ($past(scl_raw) != $past(scl_flt)));

    assert_sda_toggle_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_flt != $past(sda_flt)) |-> ($past(sda_raw) != $past(sda_flt)));
endmodule

bind i2c_spike_filter i2c_spike_filter_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .periph_en (periph_en),
    .cfg_we    (cfg_we),
    .cfg_len   (cfg_len),
    .scl_raw   (scl_raw),
    .sda_raw   (sda_raw),
    .scl_flt   (scl_flt),
    .sda_flt   (sda_flt),
    .cur_len   (cur_len)
);

// File: tb/i2c_spike_filter_tb_top.sv
module i2c_spike_filter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       periph_en = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_len = 4'd0;
    logic       scl_raw = 1'b1;
    logic       sda_raw = 1'b1;
    logic       scl_flt;
    logic       sda_flt;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    i2c_spike_filter dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .periph_en (periph_en),
        .cfg_we    (cfg_we),
        .cfg_len   (cfg_len),
        .scl_raw   (scl_raw),
        .sda_raw   (sda_raw),
        .scl_flt   (scl_flt),
        .sda_flt   (sda_flt)
    );

    // vector: {line (0=SCL,1=SDA), length[3:0], pulse width[7:0]}
    localparam int NVEC = 12;
    localparam logic [12:0] VEC [NVEC] = '{
        {1'b0, 4'd0,  8'd1},  {1'b1, 4'd0,  8'd3},
        {1'b0, 4'd1,  8'd1},  {1'b0, 4'd1,  8'd2},
        {1'b1, 4'd3,  8'd3},  {1'b1, 4'd3,  8'd4},
        {1'b0, 4'd7,  8'd5},  {1'b0, 4'd7,  8'd8},
        {1'b1, 4'd15, 8'd15}, {1'b1, 4'd15, 8'd16},
        {1'b0, 4'd15, 8'd20}, {1'b1, 4'd2,  8'd3}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic program_len(input int len);
        @(negedge clk);
        periph_en = 1'b0;
        cfg_we = 1'b1;
        cfg_len = 4'(len);
        @(negedge clk);
        cfg_we = 1'b0;
        periph_en = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // drive a low pulse of w cycles on one line and measure both outputs
    task automatic run_pulse(input int len, input int w, input bit line, input string req);
        int first = 0;
        int lows = 0;
        int other = 0;
        @(negedge clk);
        if (line) sda_raw = 1'b0; else scl_raw = 1'b0;
        for (int m = 1; m <= w + len + 3; m++) begin
            @(posedge clk);
            @(negedge clk);
            if ((line ? sda_flt : scl_flt) == 1'b0) begin
                lows++;
                if (first == 0) first = m;
            end
            if ((line ? scl_flt : sda_flt) == 1'b0) other++;
            if (m == w) begin
                if (line) sda_raw = 1'b1; else scl_raw = 1'b1;
            end
        end
        if (w > len) begin
            check(first == len + 1, {req, " R3 first low cycle"}, first, len + 1);
            check(lows == w, {req, " R3 low cycle count"}, lows, w);
        end else begin
            check(lows == 0, {req, " R4 rejected pulse"}, lows, 0);
        end
        check(other == 0, "R5 other line untouched", other, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !finished) begin
                check(1'b0, "watchdog", cycles, 100000);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(scl_flt == 1'b1, "R1 scl in reset", int'(scl_flt), 1);
        check(sda_flt == 1'b1, "R1 sda in reset", int'(sda_flt), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(scl_flt == 1'b1, "R1 scl after reset", int'(scl_flt), 1);
        check(sda_flt == 1'b1, "R1 sda after reset", int'(sda_flt), 1);
        run_pulse(0, 1, 1'b0, "R1 default length");

        for (int i = 0; i < NVEC; i++) begin
            program_len(int'(VEC[i][11:8]));
            run_pulse(int'(VEC[i][11:8]), int'(VEC[i][7:0]), VEC[i][12],
                      (VEC[i][11:8] == 4'd0) ? "R2 R6 vector" : "R6 vector");
        end

        // R7: write while enabled must be ignored
        program_len(3);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_len = 4'd0;
        @(negedge clk);
        cfg_we = 1'b0;
        repeat (2) @(negedge clk);
        run_pulse(3, 2, 1'b0, "R7 locked length");
        run_pulse(3, 4, 1'b1, "R7 locked length");

        // R8: glitches separated by one clean cycle do not accumulate
        program_len(4);
        begin
            int lows = 0;
            @(negedge clk);
            for (int m = 1; m <= 14; m++) begin
                scl_raw = !((m >= 1 && m <= 3) || (m >= 5 && m <= 7));
                @(posedge clk);
                @(negedge clk);
                if (scl_flt == 1'b0) lows++;
            end
            scl_raw = 1'b1;
            check(lows == 0, "R8 restarted count", lows, 0);
        end

        // R6: disable, reload length 0, check bypass again
        program_len(0);
        run_pulse(0, 2, 1'b1, "R6 R2 reload");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule